// File: doc/BRIEF.md
# Display Scan Output Modifier

This block sits on the scan path of a 32-row monochrome panel, between the frame memory and the row and segment drivers. For every output row the scan sequencer announces, it computes which memory row to fetch by adding a programmable start-line offset to the output row number. It then passes the fetched 128 pixel bits through three global display controls before presenting them on the segment outputs. Those controls are panel enable, forced all-on and inversion.

The block decodes its own single-byte commands from a command strobe. Command effects are held as pending values. They are copied into the active settings only when the sequencer signals the start of a new row, so no row is ever shown with a mix of old and new settings. The memory itself, contrast current and scrolling are handled elsewhere.

Top module: `scan_out_mod`

## Requirements
- R1: A command byte in the range 40h to 7Fh loads the start line S from its low six bits. Once active, output row r fetches memory row S + r, and in normal mode the fetched word appears unchanged on the segment outputs.
- R2: The memory row sum wraps modulo 64. For example, S = 63 with output row 1 fetches memory row 0.
- R3: Command A5h forces every segment bit to 1 whatever the memory holds. Command A4h returns the segments to following the memory data.
- R4: Command A7h makes each segment bit the inverse of its memory bit. Command A6h restores the normal mapping, where a 1 in memory lights the pixel.
- R5: Command AEh turns the panel off. While it is off, all segment bits are 0, the row enable `com_oe_o` is 0 (rows high-impedance) and all row selects are 0. Command AFh turns the panel on.
- R6: The controls apply in a fixed order. Panel off overrides everything. Next, forced all-on overrides inversion. Inversion acts only on memory data.
- R7: After reset the panel is off, the start line is 0, inversion is off and the segments follow the memory.
- R8: Commands change the outputs only at the next row strobe. A command accepted on the same clock edge as a row strobe first takes effect at the strobe after that one.
- R9: Command bytes outside 40h–7Fh, A4h–A7h, AEh and AFh change nothing.
- R10: While the panel is on, `com_o` is one-hot, with bit r set for the current output row r.
- R11: `mem_row_o` and `com_o` update on the edge that samples the row strobe. `seg_o` shows the corresponding processed memory word one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_byte_i | input | 8 | Command byte |
| row_strobe_i | input | 1 | Start of a new output row |
| row_idx_i | input | 5 | Output row number, 0 to 31 |
| mem_row_o | output | 6 | Memory row to fetch |
| mem_data_i | input | 128 | Pixel bits of the fetched memory row |
| seg_o | output | 128 | Segment outputs |
| com_o | output | 32 | One-hot row select |
| com_oe_o | output | 1 | Row drivers enabled; 0 means high-impedance |

## Verification
A wrong active start line shows up on `mem_row_o` as soon as the next row is scanned. Because the bench memory model gives every row a distinct word, the error also appears on `seg_o` one clock after that. A corrupted control flag is visible on the segments one clock after the row that loads it. A pending value that leaks into the active set before a row boundary changes `seg_o` between strobes, and the bench samples for exactly that after every command. Wrap-around and same-edge command/strobe cases are driven directly, and random command and row mixes cover the combinations of the three controls.

// File: rtl/scan_out_pkg.sv
package scan_out_pkg;

  typedef struct packed {
    logic panel_on;
    logic force_on;
    logic invert;
  } disp_ctrl_t;

  localparam disp_ctrl_t CTRL_RESET = '{panel_on: 1'b0, force_on: 1'b0, invert: 1'b0};

  localparam logic [7:0] OP_FOLLOW_RAM = 8'hA4;
  localparam logic [7:0] OP_ALL_ON     = 8'hA5;
  localparam logic [7:0] OP_NORMAL     = 8'hA6;
  localparam logic [7:0] OP_INVERT     = 8'hA7;
  localparam logic [7:0] OP_PANEL_OFF  = 8'hAE;
  localparam logic [7:0] OP_PANEL_ON   = 8'hAF;
  localparam logic [1:0] OP_LINE_TAG   = 2'b01;

endpackage

// File: rtl/scan_cmd_decode.sv
module scan_cmd_decode
  import scan_out_pkg::*;
#(
  parameter int LINE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_byte_i,
  output disp_ctrl_t        pend_ctrl_o,
  output logic [LINE_W-1:0] pend_start_o
);

  disp_ctrl_t        ctrl_q;
  logic [LINE_W-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RESET;
      start_q <= '0;
    end else if (cmd_valid_i) begin
      if (cmd_byte_i[7:6] == OP_LINE_TAG) begin
        start_q <= cmd_byte_i[LINE_W-1:0];
      end else begin
        case (cmd_byte_i)
          OP_FOLLOW_RAM: ctrl_q.force_on <= 1'b0;
          OP_ALL_ON:     ctrl_q.force_on <= 1'b1;
          OP_NORMAL:     ctrl_q.invert   <= 1'b0;
          OP_INVERT:     ctrl_q.invert   <= 1'b1;
          OP_PANEL_OFF:  ctrl_q.panel_on <= 1'b0;
          OP_PANEL_ON:   ctrl_q.panel_on <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign pend_ctrl_o  = ctrl_q;
  assign pend_start_o = start_q;

endmodule

// File: rtl/scan_row_map.sv
module scan_row_map
  import scan_out_pkg::*;
#(
  parameter int ROWS   = 32,
  parameter int LINE_W = 6,
  parameter int ROW_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_strobe_i,
  input  logic [ROW_W-1:0]  row_idx_i,
  input  disp_ctrl_t        pend_ctrl_i,
  input  logic [LINE_W-1:0] pend_start_i,
  output disp_ctrl_t        act_ctrl_o,
  output logic [LINE_W-1:0] mem_row_o,
  output logic [ROWS-1:0]   com_o,
  output logic              com_oe_o
);

  disp_ctrl_t        act_q;
  logic [LINE_W-1:0] start_q;
  logic [ROW_W-1:0]  row_q;

  // settings swap only on a row boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= CTRL_RESET;
      start_q <= '0;
      row_q   <= '0;
    end else if (row_strobe_i) begin
      act_q   <= pend_ctrl_i;
      start_q <= pend_start_i;
      row_q   <= row_idx_i;
    end
  end

  // natural truncation gives the modulo wrap
  assign mem_row_o  = start_q + LINE_W'(row_q);
  assign act_ctrl_o = act_q;
  assign com_oe_o   = act_q.panel_on;

  for (genvar i = 0; i < ROWS; i++) begin : g_com
    assign com_o[i] = act_q.panel_on && (row_q == ROW_W'(i));
  end

endmodule

// File: rtl/scan_pix_stage.sv
module scan_pix_stage
  import scan_out_pkg::*;
#(
  parameter int COLS = 128
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  disp_ctrl_t      act_ctrl_i,
  input  logic [COLS-1:0] mem_data_i,
  output logic [COLS-1:0] seg_o
);

  logic [COLS-1:0] seg_d;
  logic [COLS-1:0] seg_q;

  // precedence: off > all-on > invert
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign seg_d[c] = act_ctrl_i.panel_on &
                      (act_ctrl_i.force_on | (mem_data_i[c] ^ act_ctrl_i.invert));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_q <= '0;
    else         seg_q <= seg_d;
  end

  assign seg_o = seg_q;

endmodule

// File: rtl/scan_out_mod.sv
module scan_out_mod
  import scan_out_pkg::*;
#(
  parameter int ROWS     = 32,
  parameter int COLS     = 128,
  parameter int MEM_ROWS = 64,
  localparam int LINE_W  = $clog2(MEM_ROWS),
  localparam int ROW_W   = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_byte_i,
  input  logic              row_strobe_i,
  input  logic [ROW_W-1:0]  row_idx_i,
  output logic [LINE_W-1:0] mem_row_o,
  input  logic [COLS-1:0]   mem_data_i,
  output logic [COLS-1:0]   seg_o,
  output logic [ROWS-1:0]   com_o,
  output logic              com_oe_o
);

  disp_ctrl_t        pend_ctrl;
  disp_ctrl_t        act_ctrl;
  logic [LINE_W-1:0] pend_start;

  scan_cmd_decode #(.LINE_W(LINE_W)) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_byte_i   (cmd_byte_i),
    .pend_ctrl_o  (pend_ctrl),
    .pend_start_o (pend_start)
  );

  scan_row_map #(.ROWS(ROWS), .LINE_W(LINE_W), .ROW_W(ROW_W)) u_map (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .row_strobe_i (row_strobe_i),
    .row_idx_i    (row_idx_i),
    .pend_ctrl_i  (pend_ctrl),
    .pend_start_i (pend_start),
    .act_ctrl_o   (act_ctrl),
    .mem_row_o    (mem_row_o),
    .com_o        (com_o),
    .com_oe_o     (com_oe_o)
  );

  scan_pix_stage #(.COLS(COLS)) u_pix (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_ctrl_i (act_ctrl),
    .mem_data_i (mem_data_i),
    .seg_o      (seg_o)
  );

endmodule

// File: rtl/scan_out_mod_chk.sv
module scan_out_mod_chk #(
  parameter int ROWS   = 32,
  parameter int COLS   = 128,
  parameter int LINE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              row_strobe_i,
  input logic [LINE_W-1:0] mem_row_o,
  input logic [COLS-1:0]   seg_o,
  input logic [ROWS-1:0]   com_o,
  input logic              com_oe_o
);

  // R10
  com_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(com_o));

  // R10
  com_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_oe_o |-> (com_o != '0));

  // R5
  com_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !com_oe_o |-> (com_o == '0));

  // R5
  seg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !com_oe_o |=> (seg_o == '0));

  // R8
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_strobe_i |=> ($stable(mem_row_o) && $stable(com_oe_o) && $stable(com_o)));

endmodule

bind scan_out_mod scan_out_mod_chk #(.ROWS(ROWS), .COLS(COLS), .LINE_W(LINE_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .row_strobe_i (row_strobe_i),
  .mem_row_o    (mem_row_o),
  .seg_o        (seg_o),
  .com_o        (com_o),
  .com_oe_o     (com_oe_o)
);

// File: tb/scan_out_mod_tb_top.sv
module scan_out_mod_tb_top;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cmd_valid_i = 1'b0;
  logic [7:0]   cmd_byte_i = '0;
  logic         row_strobe_i = 1'b0;
  logic [4:0]   row_idx_i = '0;
  logic [5:0]   mem_row_o;
  logic [127:0] mem_data_i;
  logic [127:0] seg_o;
  logic [31:0]  com_o;
  logic         com_oe_o;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic       p_on = 0, p_force = 0, p_inv = 0;
  logic [5:0] p_start = 0;
  logic       a_on = 0, a_force = 0, a_inv = 0;
  logic [5:0] a_start = 0;
  logic [127:0] last_seg = '0;

  always #10 clk_i = ~clk_i;

  scan_out_mod dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_byte_i   (cmd_byte_i),
    .row_strobe_i (row_strobe_i),
    .row_idx_i    (row_idx_i),
    .mem_row_o    (mem_row_o),
    .mem_data_i   (mem_data_i),
    .seg_o        (seg_o),
    .com_o        (com_o),
    .com_oe_o     (com_oe_o)
  );

  function automatic logic [127:0] mem_word(input logic [5:0] r);
    logic [31:0] x;
    x = {26'd0, r};
    return {x * 32'h9E3779B1 + 32'h1, ~(x * 32'h85EBCA6B),
            (x * 32'hC2B2AE35) ^ 32'h5A5A5A5A, x | 32'hF0F00000};
  endfunction

  always_comb mem_data_i = mem_word(mem_row_o);

  function automatic logic [127:0] exp_seg(input logic on, input logic frc,
                                           input logic inv, input logic [127:0] d);
    if (!on)      return '0;
    else if (frc) return '1;
    else if (inv) return ~d;
    else          return d;
  endfunction

  task automatic model_cmd(input logic [7:0] b);
    if (b[7:6] == 2'b01) p_start = b[5:0];
    else case (b)
      8'hA4: p_force = 0;
      8'hA5: p_force = 1;
      8'hA6: p_inv = 0;
      8'hA7: p_inv = 1;
      8'hAE: p_on = 0;
      8'hAF: p_on = 1;
      default: ;
    endcase
  endtask

  task automatic check(input logic ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_byte_i  = b;
    @(posedge clk_i);
    model_cmd(b);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    // R8: pending change must not reach the segments between strobes
    check(seg_o == last_seg, "R8 seg held after command", seg_o, last_seg);
  endtask

  task automatic do_row(input logic [4:0] r, input logic with_cmd,
                        input logic [7:0] b, input string note);
    logic [5:0]   er;
    logic [127:0] es;
    logic [31:0]  ec;
    string        tag;
    @(negedge clk_i);
    row_strobe_i = 1'b1;
    row_idx_i    = r;
    if (with_cmd) begin
      cmd_valid_i = 1'b1;
      cmd_byte_i  = b;
    end
    @(posedge clk_i);
    a_on = p_on; a_force = p_force; a_inv = p_inv; a_start = p_start;
    if (with_cmd) model_cmd(b);
    @(negedge clk_i);
    row_strobe_i = 1'b0;
    cmd_valid_i  = 1'b0;
    er = a_start + 6'(r);
    ec = a_on ? (32'd1 << r) : 32'd0;
    check(mem_row_o == er, {"R1 R2 R11 mem row ", note}, 128'(mem_row_o), 128'(er));
    check(com_oe_o == a_on, {"R5 row enable ", note}, 128'(com_oe_o), 128'(a_on));
    check(com_o == ec, {"R10 row select ", note}, 128'(com_o), 128'(ec));
    @(negedge clk_i);
    es = exp_seg(a_on, a_force, a_inv, mem_word(er));
    if (!a_on)                tag = "R5";
    else if (a_force && a_inv) tag = "R6";
    else if (a_force)          tag = "R3";
    else if (a_inv)            tag = "R4";
    else                       tag = "R1";
    check(seg_o == es, {tag, " R11 segments ", note}, seg_o, es);
    last_seg = es;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7 reset state
    check(seg_o == '0, "R7 seg after reset", seg_o, '0);
    check(com_oe_o == 1'b0, "R7 rows off after reset", 128'(com_oe_o), 0);
    check(mem_row_o == 6'd0, "R7 start line after reset", 128'(mem_row_o), 0);
    do_row(5'd2, 0, 8'h00, "R7 still off");
    send_cmd(8'hAF);
    do_row(5'd5, 0, 8'h00, "R7 defaults");
    // R2 wrap
    send_cmd(8'h7F);
    do_row(5'd0, 0, 8'h00, "R2 start 63");
    do_row(5'd1, 0, 8'h00, "R2 wrap to 0");
    do_row(5'd31, 0, 8'h00, "R2 wrap 30");
    send_cmd(8'h45);
    do_row(5'd31, 0, 8'h00, "R1 start 5");
    // R4, R3, R6
    send_cmd(8'hA7);
    do_row(5'd3, 0, 8'h00, "R4 invert");
    send_cmd(8'hA5);
    do_row(5'd3, 0, 8'h00, "R6 force over invert");
    send_cmd(8'hA6);
    do_row(5'd7, 0, 8'h00, "R3 force");
    send_cmd(8'hA4);
    do_row(5'd7, 0, 8'h00, "R3 back to memory");
    // R8 same-edge command
    do_row(5'd2, 1, 8'hAE, "R8 same edge off");
    do_row(5'd4, 0, 8'h00, "R8 off next row");
    send_cmd(8'hA5);
    do_row(5'd4, 0, 8'h00, "R6 off beats force");
    send_cmd(8'hA4);
    send_cmd(8'hAF);
    // R9 ignored bytes
    send_cmd(8'h00); send_cmd(8'hFF); send_cmd(8'h3F); send_cmd(8'h80);
    send_cmd(8'hA8); send_cmd(8'hAD); send_cmd(8'hB0); send_cmd(8'hA3);
    do_row(5'd9, 0, 8'h00, "R9 ignored bytes");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 3);
      case ($urandom_range(0, 9))
        0, 1, 2, 3: b = 8'h40 | 8'($urandom_range(0, 63));
        4:          b = ($urandom_range(0, 1) != 0) ? 8'hA5 : 8'hA4;
        5:          b = ($urandom_range(0, 1) != 0) ? 8'hA7 : 8'hA6;
        6:          b = ($urandom_range(0, 3) != 0) ? 8'hAF : 8'hAE;
        default:    b = 8'($urandom_range(0, 255));
      endcase
      if (op == 0) send_cmd(b);
      else do_row(5'($urandom_range(0, 31)), ($urandom_range(0, 3) == 0), b, "random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule